// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block counts transitions on an asynchronous external input and raises a periodic interrupt. The input is first resynchronised to the system clock. A history flop then turns level changes into single-cycle edge strobes. A select code chooses whether rising or falling transitions count.

While counting is enabled, each selected edge moves an 8-bit counter forward by one. When the counter already equals the compare value, the next selected edge returns the counter to 00h and pulses the interrupt output for one system clock. A compare value of N therefore gives one interrupt for every N+1 selected edges.

The compare value is captured only while counting is disabled, so a change made during counting does not disturb the running period. Dropping the enable returns the counter to 00h and stops all interrupts.

Top module: `evt_edge_counter`

## Requirements
- R1: While enabled, each selected edge that does not end a period raises the count by exactly one, and the count does not move in cycles without a selected edge.
- R2: Select code 00h counts falling transitions of the event input, and code 01h counts rising ones. A transition of the other polarity leaves the count unchanged. The count reflects a pin change by the third rising clock edge after the pin change.
- R3: A selected edge that arrives while the count equals the compare value sets the count to 00h. The interrupt output is high in that same cycle.
- R4: The interrupt fires once for every N+1 selected edges, where N is the captured compare value (00h to FFh), and the count never exceeds N.
- R5: With N = 00h, every selected edge raises the interrupt and the count stays at 00h.
- R6: While the enable is 0, the count is 00h and no interrupt is raised, and edges on the input have no effect. After reset the count is 00h and the interrupt is low. A later enable starts counting from 00h.
- R7: The compare value follows the compare input only while the enable is 0. A change to the compare input while enabled does not alter the period.
- R8: Any select code other than 00h and 01h counts rising transitions.
- R9: The interrupt output is high for exactly one system clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_pin_i | input | 1 | External event input, asynchronous to clk_i |
| edge_sel_i | input | 8 | Edge select code: 00h falling, otherwise rising |
| cmp_val_i | input | 8 | Compare value N, captured while disabled |
| cnt_en_i | input | 1 | Count enable |
| count_o | output | 8 | Current count value |
| irq_o | output | 1 | One-cycle interrupt pulse on period end |

## Verification
Each pulse on the event input is split into its rising and falling halves, and the count is checked after each half. This separates a correct polarity choice from a swapped one, because the two choices move the count at different halves of the pulse. Compare values of 3, 2, 0 and FFh cover several period lengths: ordinary periods, the case where every edge raises the interrupt, and the full-range wrap. The input also toggles while the block is disabled, and the compare input changes while it is enabled. Both show whether stimulus that should be ignored leaks into the count or the interrupt.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    localparam int unsigned SEL_W = 8;

    // The only code that picks the falling transition; everything else counts rising
    localparam logic [SEL_W-1:0] SEL_CODE_FALL = 8'h00;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    function automatic edge_pol_e decode_pol(input logic [SEL_W-1:0] code);
        return (code == SEL_CODE_FALL) ? POL_FALL : POL_RISE;
    endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t          st_q, st_d;
    logic [STAGES-1:0] chain_next;

    // Shift structure of the synchroniser, one stage per iteration
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_next[g] = pin_i;
        end else begin : g_rest
            assign chain_next[g] = st_q.chain[g-1];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = chain_next;
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.chain[STAGES-1] & st_q.prev;

    // A strobe needs a fresh level change, so strobes never sit back to back
    AST_RISE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R2
    AST_FALL_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R2

endmodule

// File: rtl/evt_match_core.sv
module evt_match_core #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } core_st_t;

    core_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.cmp = cmp_i;
        end else if (hit_i) begin
            if (st_q.cnt == st_q.cmp) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;

    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && hit_i && (st_q.cnt != st_q.cmp)) |=> (st_q.cnt == $past(st_q.cnt) + CNT_ONE)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !hit_i) |=> $stable(st_q.cnt)); // R1
    AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (cnt_o == '0)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.cmp); // R4
    AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_o == '0) && !irq_o); // R6
    AST_CMP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $stable(st_q.cmp)); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o); // R9

endmodule

// File: rtl/evt_edge_counter.sv
module evt_edge_counter
    import evt_cnt_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_pin_i,
    input  logic [SEL_W-1:0] edge_sel_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cnt_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    logic      rise, fall, hit;
    edge_pol_e pol;

    evt_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (evt_pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        pol = decode_pol(edge_sel_i);
        hit = (pol == POL_FALL) ? fall : rise;
    end

    evt_match_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cnt_en_i),
        .hit_i  (hit),
        .cmp_i  (cmp_val_i),
        .cnt_o  (count_o),
        .irq_o  (irq_o)
    );

    // Codes above 01h must never select the falling transition
    AST_ODD_CODE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_sel_i > 8'h01) |-> (pol == POL_RISE)); // R8

endmodule

// File: tb/evt_edge_counter_bench.sv
module evt_edge_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic [7:0] sel = 8'h01;
    logic [7:0] cmp = 8'h00;
    logic       en = 1'b0;
    logic [7:0] count;
    logic       irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_edge_counter u_evt_edge_counter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .evt_pin_i  (pin),
        .edge_sel_i (sel),
        .cmp_val_i  (cmp),
        .cnt_en_i   (en),
        .count_o    (count),
        .irq_o      (irq)
    );

    typedef struct {
        int    cnt;
        bit    irq;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    // Reference model state
    int m_cnt = 0;
    int m_cmp = 0;
    bit m_en  = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int c, input bit i, input string req);
        exp_t e;
        e.cnt = c; e.irq = i; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic bit pol_fall(input logic [7:0] code);
        return code == 8'h00;
    endfunction

    // Drive one transition of the pin, predict the effect, then check the count
    task automatic apply_edge(input bit to_high, input string req);
        @(negedge clk);
        pin = to_high;
        if (m_en && (to_high != pol_fall(sel))) begin
            if (m_cnt == m_cmp) begin
                m_cnt = 0;
                push(0, 1'b1, req);
            end else begin
                m_cnt++;
                push(m_cnt, 1'b0, req);
            end
        end
        repeat (SETTLE) @(negedge clk);
        check(count == 8'(m_cnt), "R2 count after pin transition", int'(count), m_cnt);
    endtask

    task automatic pulses(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            apply_edge(1'b1, req);
            apply_edge(1'b0, req);
        end
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en = v;
        if (v) begin
            m_cmp = int'(cmp);
        end else if (m_cnt != 0) begin
            push(0, 1'b0, "R6 disable clears");
        end
        m_en  = v;
        m_cnt = 0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: every change of count or irq is a produced result
    int last_cnt = 0;
    bit last_irq = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if ((int'(count) != last_cnt) || irq) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected result", int'(count), last_cnt);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(count) == e.cnt, e.req, int'(count), e.cnt);
                    check(irq == e.irq, {e.req, " irq (R3)"}, int'(irq), int'(e.irq));
                end
            end
            if (last_irq) begin
                check(!irq, "R9 irq one cycle", int'(irq), 0);
            end
            last_cnt = int'(count);
            last_irq = irq;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(count == 8'h00, "R6 reset count", int'(count), 0);
        check(irq == 1'b0, "R6 reset irq", int'(irq), 0);

        // R1 R4: rising edges, N=3 gives an interrupt every fourth edge
        sel = 8'h01; cmp = 8'd3;
        set_en(1'b1);
        pulses(9, "R4 period N=3");

        // R7: compare change while enabled is ignored
        cmp = 8'd1;
        pulses(4, "R7 compare frozen");
        set_en(1'b0);

        // R6: edges while disabled have no effect
        pulses(3, "R6 disabled");
        check(count == 8'h00, "R6 count held at zero", int'(count), 0);

        // R2: falling selection, N=2
        sel = 8'h00; cmp = 8'd2;
        set_en(1'b1);
        pulses(7, "R1 falling N=2");
        set_en(1'b0);

        // R5: N=0, every edge interrupts
        sel = 8'h01; cmp = 8'd0;
        set_en(1'b1);
        pulses(3, "R5 N=0");
        set_en(1'b0);

        // R8 with R4 full range: odd select code, N=FFh
        sel = 8'h5A; cmp = 8'hFF;
        set_en(1'b1);
        pulses(258, "R8 rising on odd code, N=FF");
        set_en(1'b0);

        repeat (SETTLE) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected results seen", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule